// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block turns a level-sensitive maskable interrupt request into the bus traffic that fetches the interrupt vector. It first sees the request while the interrupt-enable flag is set. It then waits for the core to report that the instruction in flight has retired. After that it runs two interrupt-acknowledge bus cycles, one straight after the other, and holds the bus lock across both. The byte returned with the second acknowledge is captured and handed to the core together with a one-clock valid strobe. The core uses it to select the handler.

The request is checked again at the moment the first acknowledge would be launched. If the request is no longer active at that point, or the enable flag has been cleared, the sequence is abandoned and nothing reaches the bus. The bus side is a plain request/ready handshake. A cycle stays requested until ready is sampled high, and the cycle-type code tells the outside which acknowledge is running.

Top module: `intack_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, cyc_req, bus_lock and vec_valid are 0 and cyc_type is 2'b00.
- R2: A request is never serviced while int_en is 0: with int_en low, or int_en cleared before the boundary strobe is sampled, no bus cycle is requested.
- R3: No acknowledge cycle is requested before insn_done is sampled high after the request was seen. The first cycle request appears in the cycle after that sample.
- R4: If irq_req is low at any edge before the first acknowledge is launched, including the edge where insn_done is sampled, the sequence is dropped and no bus cycle is requested.
- R5: The first acknowledge drives cyc_req=1, cyc_type=2'b01 and bus_lock=1, and holds them until bus_rdy is sampled high.
- R6: In the cycle after the first bus_rdy, the second acknowledge starts with cyc_req=1, cyc_type=2'b10 and bus_lock=1. bus_lock has no low cycle between the two acknowledges.
- R7: cyc_req and bus_lock fall to 0 in the cycle after bus_rdy is sampled for the second acknowledge.
- R8: vec takes the value of ack_data sampled with the second acknowledge's bus_rdy. The data returned on the first acknowledge never reaches vec.
- R9: vec_valid is high for exactly one clock, in the cycle after the second acknowledge's bus_rdy.
- R10: A request held high through delivery is not taken again before the strobe has been issued. The next first acknowledge begins no earlier than three cycles after vec_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Maskable interrupt request, level |
| int_en | input | 1 | Interrupt-enable flag from the core |
| insn_done | input | 1 | Instruction-boundary strobe |
| bus_rdy | input | 1 | Ready for the current bus cycle |
| ack_data | input | VEC_W | Low byte lane of the bus data |
| cyc_req | output | 1 | Bus cycle request |
| cyc_type | output | 2 | 00 none, 01 first acknowledge, 10 second acknowledge |
| bus_lock | output | 1 | Bus lock held across both acknowledges |
| vec_valid | output | 1 | One-clock vector strobe to the core |
| vec | output | VEC_W | Captured interrupt vector |

## Verification
The critical collision is the request dropping on the same edge where the boundary strobe is sampled. Launch and abandonment are then decided in one cycle, and abandonment must win. The bench provokes this by lowering irq_req and raising insn_done together while the sequencer waits. It judges the result by cyc_req and bus_lock staying low for the following cycles. A second overlap is a request still held high while the vector is being delivered. That case is judged by counting the cycles from vec_valid to the next first-acknowledge request.

// File: rtl/intack_pkg.sv
package intack_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_ACK1,
    S_ACK2,
    S_DELIVER
  } seq_state_e;

  localparam int CT_W = 2;
  localparam logic [CT_W-1:0] CT_NONE       = 2'b00;
  localparam logic [CT_W-1:0] CT_ACK_FIRST  = 2'b01;
  localparam logic [CT_W-1:0] CT_ACK_SECOND = 2'b10;
endpackage

// File: rtl/intack_ctrl.sv
module intack_ctrl
  import intack_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       irq_req,
  input  logic       int_en,
  input  logic       insn_done,
  input  logic       bus_rdy,
  output seq_state_e nxt_state,
  output logic       cap_stb
);
  seq_state_e state_q;
  logic       armed;

  assign armed = irq_req && int_en;

  always_comb begin
    nxt_state = state_q;
    cap_stb   = 1'b0;
    case (state_q)
      S_IDLE:    if (armed) nxt_state = S_WAIT;
      S_WAIT: begin
        if (!armed)         nxt_state = S_IDLE;
        else if (insn_done) nxt_state = S_ACK1;
      end
      S_ACK1:    if (bus_rdy) nxt_state = S_ACK2;
      S_ACK2: begin
        if (bus_rdy) begin
          nxt_state = S_DELIVER;
          cap_stb   = 1'b1;
        end
      end
      S_DELIVER: nxt_state = S_IDLE;
      default:   nxt_state = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= nxt_state;
  end

  // R4: a request lost while waiting abandons the sequence
  p_drop_cancels_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WAIT && !irq_req) |=> (state_q == S_IDLE));

  // R10: after delivery the sequencer always passes through idle
  p_deliver_to_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DELIVER) |=> (state_q == S_IDLE));
endmodule

// File: rtl/intack_bus_if.sv
module intack_bus_if
  import intack_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  seq_state_e      nxt_state,
  output logic            cyc_req,
  output logic [CT_W-1:0] cyc_type,
  output logic            bus_lock
);
  logic            req_d;
  logic [CT_W-1:0] type_d;

  always_comb begin
    req_d  = (nxt_state == S_ACK1) || (nxt_state == S_ACK2);
    type_d = CT_NONE;
    if (nxt_state == S_ACK1) type_d = CT_ACK_FIRST;
    if (nxt_state == S_ACK2) type_d = CT_ACK_SECOND;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_req  <= 1'b0;
      cyc_type <= CT_NONE;
      bus_lock <= 1'b0;
    end else begin
      cyc_req  <= req_d;
      cyc_type <= type_d;
      bus_lock <= req_d;
    end
  end

  // R6: the first acknowledge is followed by itself or the second, still locked
  p_gapless_second_r6: assert property (@(posedge clk) disable iff (rst)
    (cyc_type == CT_ACK_FIRST) |=>
      ((cyc_type == CT_ACK_FIRST || cyc_type == CT_ACK_SECOND) && bus_lock));

  // R5: the second acknowledge is only entered from the first
  p_second_after_first_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cyc_type == CT_ACK_SECOND) |-> ($past(cyc_type) == CT_ACK_FIRST));
endmodule

// File: rtl/intack_vec_cap.sv
module intack_vec_cap #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_stb,
  input  logic [VEC_W-1:0] din,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid <= 1'b0;
      vec       <= '0;
    end else begin
      vec_valid <= cap_stb;
      if (cap_stb) vec <= din;
    end
  end

  // R9: strobe lasts a single clock
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);

  // R8: the vector equals the data presented on the capturing edge
  p_vector_matches_r8: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec == $past(din)));
endmodule

// File: rtl/intack_seq.sv
module intack_seq
  import intack_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_req,
  input  logic             int_en,
  input  logic             insn_done,
  input  logic             bus_rdy,
  input  logic [VEC_W-1:0] ack_data,
  output logic             cyc_req,
  output logic [CT_W-1:0]  cyc_type,
  output logic             bus_lock,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec
);
  seq_state_e nxt_state;
  logic       cap_stb;

  intack_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .irq_req   (irq_req),
    .int_en    (int_en),
    .insn_done (insn_done),
    .bus_rdy   (bus_rdy),
    .nxt_state (nxt_state),
    .cap_stb   (cap_stb)
  );

  intack_bus_if u_bus (
    .clk       (clk),
    .rst       (rst),
    .nxt_state (nxt_state),
    .cyc_req   (cyc_req),
    .cyc_type  (cyc_type),
    .bus_lock  (bus_lock)
  );

  intack_vec_cap #(.VEC_W(VEC_W)) u_vec (
    .clk       (clk),
    .rst       (rst),
    .cap_stb   (cap_stb),
    .din       (ack_data),
    .vec_valid (vec_valid),
    .vec       (vec)
  );

  // R3: a cycle only starts after an enabled request met a boundary strobe
  p_launch_on_boundary_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cyc_req) |-> $past(irq_req && insn_done));

  // R2: the enable flag gates every launch
  p_enable_gate_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cyc_req) |-> $past(int_en));

  // R7: lock is released together with vector delivery
  p_lock_release_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_lock) |-> vec_valid);
endmodule

// File: tb/intack_seq_tb.sv
module intack_seq_tb;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          irq_req, int_en, insn_done, bus_rdy;
  logic [VW-1:0] ack_data;
  logic          cyc_req, bus_lock, vec_valid;
  logic [1:0]    cyc_type;
  logic [VW-1:0] vec;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  intack_seq #(.VEC_W(VW)) u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .int_en(int_en),
    .insn_done(insn_done), .bus_rdy(bus_rdy), .ack_data(ack_data),
    .cyc_req(cyc_req), .cyc_type(cyc_type), .bus_lock(bus_lock),
    .vec_valid(vec_valid), .vec(vec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    irq_req = 0; int_en = 0; insn_done = 0; bus_rdy = 0; ack_data = '0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst = 1;
    step(); step();
    chk("R1 req in reset", {31'd0, cyc_req}, 0);
    chk("R1 lock in reset", {31'd0, bus_lock}, 0);
    chk("R1 type in reset", {30'd0, cyc_type}, 0);
    rst = 0;
    step();
    chk("R1 valid after reset", {31'd0, vec_valid}, 0);
    chk("R1 req after reset", {31'd0, cyc_req}, 0);
  endtask

  task automatic t_disabled();
    irq_req = 1; int_en = 0; insn_done = 1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R2 enable low", {31'd0, cyc_req}, 0);
    end
    insn_done = 0; int_en = 1;
    step();
    int_en = 0; insn_done = 1;
    step();
    chk("R2 enable cleared before launch", {31'd0, cyc_req}, 0);
    step();
    chk("R2 enable cleared later", {31'd0, cyc_req}, 0);
    idle_inputs();
    step(); step();
  endtask

  task automatic t_drop_early();
    irq_req = 1; int_en = 1;
    step();
    irq_req = 0;
    step();
    insn_done = 1;
    step();
    chk("R4 drop before boundary", {31'd0, cyc_req}, 0);
    step();
    chk("R4 drop before boundary lock", {31'd0, bus_lock}, 0);
    idle_inputs();
    step();
  endtask

  task automatic t_drop_coincident();
    irq_req = 1; int_en = 1;
    step();
    irq_req = 0; insn_done = 1;
    step();
    chk("R4 drop with boundary req", {31'd0, cyc_req}, 0);
    chk("R4 drop with boundary lock", {31'd0, bus_lock}, 0);
    step();
    chk("R4 drop with boundary later", {31'd0, cyc_req}, 0);
    idle_inputs();
    step();
  endtask

  task automatic t_full_seq();
    irq_req = 1; int_en = 1;
    step();
    for (int i = 0; i < 3; i++) begin
      chk("R3 no cycle before boundary", {31'd0, cyc_req}, 0);
      step();
    end
    insn_done = 1;
    step();
    insn_done = 0;
    chk("R3 launch after boundary", {31'd0, cyc_req}, 1);
    chk("R5 first type", {30'd0, cyc_type}, 1);
    chk("R5 first lock", {31'd0, bus_lock}, 1);
    step(); step();
    chk("R5 first held", {30'd0, cyc_type}, 1);
    chk("R5 lock held", {31'd0, bus_lock}, 1);
    bus_rdy = 1; ack_data = 8'hA5;
    step();
    bus_rdy = 0; ack_data = 8'h00; irq_req = 0;
    chk("R6 second type", {30'd0, cyc_type}, 2);
    chk("R6 second req", {31'd0, cyc_req}, 1);
    chk("R6 lock continuous", {31'd0, bus_lock}, 1);
    chk("R9 no strobe early", {31'd0, vec_valid}, 0);
    step();
    chk("R6 second held", {30'd0, cyc_type}, 2);
    bus_rdy = 1; ack_data = 8'h3C;
    step();
    bus_rdy = 0; ack_data = 8'hFF;
    chk("R7 req released", {31'd0, cyc_req}, 0);
    chk("R7 lock released", {31'd0, bus_lock}, 0);
    chk("R9 strobe", {31'd0, vec_valid}, 1);
    chk("R8 vector from second", {24'd0, vec}, 32'h3C);
    step();
    chk("R9 strobe one clock", {31'd0, vec_valid}, 0);
    chk("R8 vector kept", {24'd0, vec}, 32'h3C);
    idle_inputs();
    step();
  endtask

  task automatic t_held_request();
    irq_req = 1; int_en = 1; insn_done = 1; bus_rdy = 1; ack_data = 8'h77;
    step(); step();
    chk("R5 immediate launch", {30'd0, cyc_type}, 1);
    step();
    chk("R6 zero-wait second", {30'd0, cyc_type}, 2);
    step();
    chk("R9 strobe held req", {31'd0, vec_valid}, 1);
    chk("R8 vector held req", {24'd0, vec}, 32'h77);
    step();
    chk("R10 no relaunch +1", {31'd0, cyc_req}, 0);
    step();
    chk("R10 no relaunch +2", {31'd0, cyc_req}, 0);
    step();
    chk("R10 relaunch +3", {31'd0, cyc_req}, 1);
    chk("R10 relaunch type", {30'd0, cyc_type}, 1);
    irq_req = 0; insn_done = 0; ack_data = 8'h12;
    step(); step();
    chk("R8 second vector", {24'd0, vec}, 32'h12);
    chk("R9 second strobe", {31'd0, vec_valid}, 1);
    idle_inputs();
    step();
    chk("R7 idle after", {31'd0, bus_lock}, 0);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_drop_early();
    t_drop_coincident();
    t_full_seq();
    t_held_request();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule